// File: doc/BRIEF.md
# Two-Dimensional DMA Address Stepper

This block is the stepping core of a single DMA channel. A data mover offers one element at a time on an accept handshake. For every element the block takes, it moves the current memory address by a signed X stride and lowers the remaining X count. Once a row is used up, the block does one of three things. It can jump to the next row of a two-dimensional pattern. It can finish the work unit and park with a done flag. Or it can ask a descriptor loader for fresh parameters and keep running once the loader answers.

Software-visible registers belong to the surrounding channel and are wired in as plain inputs: start address, X/Y counts, X/Y strides and configuration bits. A start pulse loads a work unit into the current address and counters. The direction bit steers each accepted element to one of two strobes: memory write (data coming from the peripheral) or memory read (data going to the peripheral). A completion interrupt pulse can be raised at the end of every row.

Top module: `dma_stride_engine`

## Requirements
- R1: Each accepted element (`elem_valid` and `elem_ready` high at a clock edge) that does not end a row in 2D mode adds the X stride, sign-extended from 16 bits, to `cur_addr` and lowers `cur_x` by one.
- R2: When `cfg_irq_en` is 1, accepting the last element of a row (`cur_x` equal to 1) makes `irq` high for exactly the following cycle. When `cfg_irq_en` is 0, `irq` stays low.
- R3: With `cfg_2d` at 1 and `cur_y` above 1, the last element of a row lowers `cur_y` by one and reloads `cur_x` from `x_count`. It sets `cur_addr` to the old address plus the Y stride, which equals the stepped address minus the X stride plus the Y stride.
- R4: With `cfg_flow` equal to 0 (stop), the end of the work unit clears `run`, sets `done` and drops `elem_ready`.
- R5: With `cfg_flow` not equal to 0, the end of the work unit raises `reload_req` and keeps `run` high. `elem_ready` stays low, and `cur_addr` does not change, until `reload_ack`. The cycle after `reload_ack`, the new `start_addr`, `x_count` and `y_count` are in force.
- R6: With `cfg_2d` at 0, `y_count` has no effect: the work unit ends after `x_count` elements.
- R7: An `x_count` or `y_count` of 0 loads a current count of 65536.
- R8: Address arithmetic wraps modulo 2^32 in both directions.
- R9: During an accepted element, `xfer_to_mem` is high if `cfg_dir` is 1 and `xfer_from_mem` is high if `cfg_dir` is 0. Neither strobe is high without an accepted element.
- R10: A `start` pulse while `run` is high is ignored.
- R11: After reset, `run`, `done`, `irq`, `reload_req` and `elem_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load a work unit and begin running |
| start_addr | input | 32 | First address of the work unit |
| x_count | input | 16 | Elements per row (0 means 65536) |
| x_modify | input | 16 | Signed X stride |
| y_count | input | 16 | Rows per work unit in 2D mode (0 means 65536) |
| y_modify | input | 16 | Signed Y stride |
| cfg_2d | input | 1 | Two-dimensional mode |
| cfg_irq_en | input | 1 | Interrupt at end of each row |
| cfg_flow | input | 2 | 0 stop, other values request reload |
| cfg_dir | input | 1 | 1 memory write, 0 memory read |
| elem_valid | input | 1 | Data mover offers an element |
| elem_ready | output | 1 | Block accepts an element |
| reload_ack | input | 1 | Loader has placed new parameters |
| reload_req | output | 1 | Descriptor reload pending |
| cur_addr | output | 32 | Current address |
| cur_x | output | 17 | Remaining elements in the row |
| cur_y | output | 17 | Remaining rows |
| run | output | 1 | Channel running |
| done | output | 1 | Work unit complete (stop flow) |
| irq | output | 1 | Completion interrupt pulse |
| xfer_to_mem | output | 1 | Accepted element is written to memory |
| xfer_from_mem | output | 1 | Accepted element is read from memory |

## Verification
The interrupt pulse can fall in the same cycle as either a 2D row jump or the end of the work unit, because both are decided on the same accepted element. The sweep enables the interrupt across every combination of row length, row count and stride, and keeps elements streaming with no gaps so that row ends follow each other directly. It then compares the number of interrupt pulses with the number of rows, and the address just after each jump with an arithmetic prediction. A lost or doubled pulse, or a jump that misapplies the stride, therefore shows up as a count or address mismatch.

// File: rtl/dma_step_pkg.sv
package dma_step_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned MOD_W  = 16;
    localparam int unsigned CNT_W  = 16;

    typedef enum logic [1:0] {
        FLOW_HALT   = 2'd0,
        FLOW_REPEAT = 2'd1,
        FLOW_SHORT  = 2'd2,
        FLOW_LONG   = 2'd3
    } flow_e;

    typedef struct packed {
        logic load;
        logic jump;
        logic step;
    } addr_cmd_t;

    function automatic logic is_halt(input logic [1:0] f);
        return flow_e'(f) == FLOW_HALT;
    endfunction

endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
    parameter int unsigned AW = dma_step_pkg::ADDR_W,
    parameter int unsigned MW = dma_step_pkg::MOD_W
) (
    input  logic [AW-1:0] base_addr,
    input  logic [MW-1:0] x_mod,
    input  logic [MW-1:0] y_mod,
    output logic [AW-1:0] step_addr,
    output logic [AW-1:0] jump_addr
);
    localparam int unsigned EXT_W = AW - MW;

    logic [AW-1:0] x_ext;
    logic [AW-1:0] y_ext;

    always_comb begin
        x_ext     = {{EXT_W{x_mod[MW-1]}}, x_mod};
        y_ext     = {{EXT_W{y_mod[MW-1]}}, y_mod};
        step_addr = base_addr + x_ext;
        jump_addr = base_addr + y_ext;
    end
endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
    parameter int unsigned CW = dma_step_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          row_wrap,
    input  logic          dec_x,
    input  logic [CW-1:0] x_init,
    input  logic [CW-1:0] y_init,
    output logic [CW:0]   x_cnt,
    output logic [CW:0]   y_cnt,
    output logic          x_last,
    output logic          y_more
);
    localparam logic [CW:0] FULL = (CW+1)'(1) << CW;

    function automatic logic [CW:0] widen(input logic [CW-1:0] v);
        return (v == '0) ? FULL : {1'b0, v};
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            x_cnt <= '0;
            y_cnt <= '0;
        end else if (load) begin
            x_cnt <= widen(x_init);
            y_cnt <= widen(y_init);
        end else if (row_wrap) begin
            x_cnt <= widen(x_init);
            y_cnt <= y_cnt - 1'b1;
        end else if (dec_x) begin
            x_cnt <= x_cnt - 1'b1;
        end
    end

    assign x_last = (x_cnt == (CW+1)'(1));
    assign y_more = (y_cnt > (CW+1)'(1));

    AST_X_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        dec_x |-> x_cnt != '0) else $error("x count underflow"); // R1

    AST_Y_WRAP_DEC: assert property (@(posedge clk) disable iff (rst)
        row_wrap && !load |=> y_cnt == $past(y_cnt) - 1'b1) else $error("y not decremented"); // R3
endmodule

// File: rtl/dma_stride_engine.sv
module dma_stride_engine
    import dma_step_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned MW = MOD_W,
    parameter int unsigned CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] x_count,
    input  logic [MW-1:0] x_modify,
    input  logic [CW-1:0] y_count,
    input  logic [MW-1:0] y_modify,
    input  logic          cfg_2d,
    input  logic          cfg_irq_en,
    input  logic [1:0]    cfg_flow,
    input  logic          cfg_dir,
    input  logic          elem_valid,
    output logic          elem_ready,
    input  logic          reload_ack,
    output logic          reload_req,
    output logic [AW-1:0] cur_addr,
    output logic [CW:0]   cur_x,
    output logic [CW:0]   cur_y,
    output logic          run,
    output logic          done,
    output logic          irq,
    output logic          xfer_to_mem,
    output logic          xfer_from_mem
);
    localparam int unsigned EXT_W = AW - MW;

    logic          fire, row_end, unit_end, halt_end;
    logic          x_last, y_more;
    logic          pend;
    logic [AW-1:0] step_addr, jump_addr;
    addr_cmd_t     cmd;

    assign elem_ready = run & ~pend;
    assign fire       = elem_valid & elem_ready;
    assign row_end    = fire & x_last;

    always_comb begin
        cmd.load = (start & ~run) | (pend & reload_ack);
        cmd.jump = row_end & cfg_2d & y_more;
        cmd.step = fire & ~cmd.jump;
    end

    assign unit_end = row_end & ~cmd.jump;
    assign halt_end = unit_end & is_halt(cfg_flow);

    dma_addr_unit #(.AW(AW), .MW(MW)) u_addr (
        .base_addr (cur_addr),
        .x_mod     (x_modify),
        .y_mod     (y_modify),
        .step_addr (step_addr),
        .jump_addr (jump_addr)
    );

    dma_count_unit #(.CW(CW)) u_count (
        .clk      (clk),
        .rst      (rst),
        .load     (cmd.load),
        .row_wrap (cmd.jump),
        .dec_x    (cmd.step),
        .x_init   (x_count),
        .y_init   (y_count),
        .x_cnt    (cur_x),
        .y_cnt    (cur_y),
        .x_last   (x_last),
        .y_more   (y_more)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
        end else if (cmd.load) begin
            cur_addr <= start_addr;
        end else if (cmd.jump) begin
            cur_addr <= jump_addr;
        end else if (cmd.step) begin
            cur_addr <= step_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            done <= 1'b0;
            pend <= 1'b0;
            irq  <= 1'b0;
        end else begin
            irq <= row_end & cfg_irq_en;
            if (start && !run) begin
                run  <= 1'b1;
                done <= 1'b0;
            end else if (halt_end) begin
                run  <= 1'b0;
                done <= 1'b1;
            end
            if (unit_end && !is_halt(cfg_flow)) begin
                pend <= 1'b1;
            end else if (pend && reload_ack) begin
                pend <= 1'b0;
            end
        end
    end

    assign reload_req    = pend;
    assign xfer_to_mem   = fire & cfg_dir;
    assign xfer_from_mem = fire & ~cfg_dir;

    AST_STEP_ADDR: assert property (@(posedge clk) disable iff (rst)
        cmd.step |=> cur_addr == $past(cur_addr)
            + {{EXT_W{$past(x_modify[MW-1])}}, $past(x_modify)}) else $error("step address"); // R1

    AST_IRQ_AFTER_ROW: assert property (@(posedge clk) disable iff (rst)
        row_end && cfg_irq_en |=> irq) else $error("missing irq"); // R2

    AST_JUMP_ADDR: assert property (@(posedge clk) disable iff (rst)
        cmd.jump |=> cur_addr == $past(cur_addr)
            + {{EXT_W{$past(y_modify[MW-1])}}, $past(y_modify)}) else $error("row jump address"); // R3

    AST_HALT_DONE: assert property (@(posedge clk) disable iff (rst)
        halt_end |=> !run && done && !elem_ready) else $error("halt completion"); // R4

    AST_RELOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        reload_req && !reload_ack |=> reload_req && run && $stable(cur_addr)) else $error("reload hold"); // R5

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        run && start && !elem_valid && !reload_ack |=> $stable(cur_addr)) else $error("start while running"); // R10
endmodule

// File: tb/dma_stride_engine_bench.sv
module dma_stride_engine_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [15:0] x_count = '0, x_modify = '0, y_count = '0, y_modify = '0;
    logic        cfg_2d = 1'b0, cfg_irq_en = 1'b0, cfg_dir = 1'b0;
    logic [1:0]  cfg_flow = 2'd0;
    logic        elem_valid = 1'b0, reload_ack = 1'b0;
    logic        elem_ready, reload_req, run, done, irq, xfer_to_mem, xfer_from_mem;
    logic [31:0] cur_addr;
    logic [16:0] cur_x, cur_y;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dma_stride_engine u_dma_stride_engine (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .x_count(x_count), .x_modify(x_modify), .y_count(y_count), .y_modify(y_modify),
        .cfg_2d(cfg_2d), .cfg_irq_en(cfg_irq_en), .cfg_flow(cfg_flow), .cfg_dir(cfg_dir),
        .elem_valid(elem_valid), .elem_ready(elem_ready), .reload_ack(reload_ack),
        .reload_req(reload_req), .cur_addr(cur_addr), .cur_x(cur_x), .cur_y(cur_y),
        .run(run), .done(done), .irq(irq), .xfer_to_mem(xfer_to_mem), .xfer_from_mem(xfer_from_mem)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic kick(input logic [31:0] a, input int xc, input int xm,
                        input int yc, input int ym, input bit d2, input bit ie, input logic [1:0] fl);
        start_addr = a; x_count = 16'(xc); x_modify = 16'(xm);
        y_count = 16'(yc); y_modify = 16'(ym);
        cfg_2d = d2; cfg_irq_en = ie; cfg_flow = fl;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        int xms[3];
        int yms[3];
        xms = '{1, 4, -2};
        yms = '{16, -8, 3};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(!run && !done && !irq && !reload_req && !elem_ready, "R11",
            {run, done, irq, reload_req, elem_ready}, 0);

        // Sweep: R1 R2 R3 R4 R6
        for (int xc = 1; xc <= 3; xc++)
        for (int yc = 1; yc <= 3; yc++)
        for (int d2 = 0; d2 <= 1; d2++)
        for (int ie = 0; ie <= 1; ie++)
        for (int mi = 0; mi < 3; mi++) begin
            int a, rows, stride, irqs, fin;
            a = 32'h1000 + xc * 64 + yc * 8;
            kick(32'(a), xc, xms[mi], yc, yms[mi], d2[0], ie[0], 2'd0);
            rows = d2 ? yc : 1;
            stride = (xc - 1) * xms[mi] + yms[mi];
            irqs = 0;
            for (int r = 0; r < rows; r++)
            for (int c = 0; c < xc; c++) begin
                int e;
                if (irq) irqs++;
                e = a + r * stride + c * xms[mi];
                chk(cur_addr == 32'(e) && elem_ready, d2 ? "R3" : "R1", cur_addr, 32'(e));
                elem_valid = 1'b1;
                @(negedge clk);
            end
            elem_valid = 1'b0;
            if (irq) irqs++;
            fin = a + (rows - 1) * stride + xc * xms[mi];
            chk(cur_addr == 32'(fin), d2 ? "R3" : "R6", cur_addr, 32'(fin));
            chk(!run && done && !elem_ready, "R4", {run, done, elem_ready}, 3'b010);
            @(negedge clk);
            if (irq) irqs++;
            chk(irqs == (ie ? rows : 0), "R2", irqs, ie ? rows : 0);
        end

        // R8 wraparound upward, R9 direction to memory
        cfg_dir = 1'b1;
        kick(32'hFFFF_FFFE, 2, 4, 1, 0, 1'b0, 1'b0, 2'd0);
        elem_valid = 1'b1;
        #1;
        chk(xfer_to_mem && !xfer_from_mem, "R9", {xfer_to_mem, xfer_from_mem}, 2'b10);
        @(negedge clk);
        chk(cur_addr == 32'h2, "R8", cur_addr, 32'h2);
        @(negedge clk);
        elem_valid = 1'b0;
        chk(!xfer_to_mem && !xfer_from_mem, "R9", {xfer_to_mem, xfer_from_mem}, 0);
        // R8 wraparound downward, R9 direction from memory
        cfg_dir = 1'b0;
        kick(32'h2, 1, -4, 1, 0, 1'b0, 1'b0, 2'd0);
        elem_valid = 1'b1;
        #1;
        chk(!xfer_to_mem && xfer_from_mem, "R9", {xfer_to_mem, xfer_from_mem}, 2'b01);
        @(negedge clk);
        elem_valid = 1'b0;
        chk(cur_addr == 32'hFFFF_FFFE && done, "R8", cur_addr, 32'hFFFF_FFFE);

        // R10 start while running is ignored
        kick(32'h100, 3, 1, 1, 0, 1'b0, 1'b0, 2'd0);
        elem_valid = 1'b1;
        @(negedge clk);
        elem_valid = 1'b0;
        start_addr = 32'h900; x_count = 16'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cur_addr == 32'h101 && cur_x == 17'd2, "R10", cur_addr, 32'h101);
        elem_valid = 1'b1;
        repeat (2) @(negedge clk);
        elem_valid = 1'b0;
        chk(done && cur_addr == 32'h103, "R10", cur_addr, 32'h103);

        // R5 reload flow
        kick(32'h200, 2, 2, 1, 0, 1'b0, 1'b0, 2'd1);
        elem_valid = 1'b1;
        repeat (2) @(negedge clk);
        chk(reload_req && run && !elem_ready, "R5", {reload_req, run, elem_ready}, 3'b110);
        repeat (3) @(negedge clk);
        chk(cur_addr == 32'h204 && reload_req, "R5", cur_addr, 32'h204);
        elem_valid = 1'b0;
        start_addr = 32'h5000; x_count = 16'd1; x_modify = 16'd1; cfg_flow = 2'd0;
        reload_ack = 1'b1;
        @(negedge clk);
        reload_ack = 1'b0;
        chk(cur_addr == 32'h5000 && cur_x == 17'd1 && !reload_req && elem_ready, "R5",
            cur_addr, 32'h5000);
        elem_valid = 1'b1;
        @(negedge clk);
        elem_valid = 1'b0;
        chk(done && !run && cur_addr == 32'h5001, "R5", cur_addr, 32'h5001);

        // R7 zero counts load 65536
        kick(32'h0, 0, 1, 0, 1, 1'b1, 1'b0, 2'd0);
        chk(cur_x == 17'h10000 && cur_y == 17'h10000, "R7", {cur_x, cur_y}, {17'h10000, 17'h10000});
        elem_valid = 1'b1;
        @(negedge clk);
        elem_valid = 1'b0;
        chk(cur_x == 17'hFFFF && cur_addr == 32'h1, "R7", cur_x, 17'hFFFF);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!run && !done && !elem_ready, "R11", {run, done, elem_ready}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule